// File: doc/BRIEF.md
# Receiver Acknowledge Decision Unit

This unit decides, once per received byte, whether a two-wire serial bus receiver pulls the data line low (acknowledge) or leaves it released (no-acknowledge). It serves both receiver roles. As a slave receiver it acknowledges by default. As a master receiver it uses an internal down-counter of bytes still expected, and it refuses the final byte so that the remote transmitter stops.

Software can force a refusal of the next byte through a one-shot request bit. The unit clears that bit by itself once the refusal has been sent. The decision is frozen on the clock rising edge of the byte's last data bit and held through the acknowledge window. A request that arrives too late therefore moves to the following byte. The bit engine that produces the phase strobes, address matching and the register bus sit outside this unit. Here the strobes are single-cycle pulses. While the role input marks the module as a transmitter, the unit is inert.

Top module: `rx_ack_ctrl`

## Requirements
- R1: After a synchronous reset, `ack_drive_low` is 0, `nack_req` is 0 and `bytes_left` is 0.
- R2: In the slave role (`role_master`=0, `role_tx`=0), with `nack_req`=0 at the last-bit strobe, the acknowledge window shows `ack_drive_low`=1 (acknowledge).
- R3: In the master role with `nack_req`=0, the window acknowledges when `bytes_left` is 2 or more at the last-bit strobe. It refuses (`ack_drive_low`=0) when `bytes_left` is 1 or 0.
- R4: When `nack_req` is 1 at the last-bit strobe, the window refuses in either receiver role, whatever `bytes_left` holds.
- R5: A request that produced a refusal reads 0 on `nack_req` from the cycle after the `ack_end` strobe of that window.
- R6: A request written in the same cycle as the last-bit strobe, or later, does not affect that byte. It stays set and refuses the next byte.
- R7: While `role_tx`=1, `ack_drive_low` stays 0, `nack_req` changes only by software write, and `bytes_left` changes only by load.
- R8: A software write of 1 in the same cycle as the automatic clear wins, and `nack_req` stays 1.
- R9: `bytes_left` loads from `cnt_load_val` on `cnt_load`. It decrements by one at each `ack_end` in the master receiver role and holds at 0. A load in the same cycle as a decrement wins.
- R10: `ack_drive_low` takes its value in the cycle after `ack_start` and holds it until the cycle after `ack_end`, when it returns to 0. A request written inside the window does not change the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master receiver, 0 = slave receiver |
| role_tx | input | 1 | 1 = module is transmitting; unit inert |
| nack_req_wr | input | 1 | Software write strobe for the request bit |
| nack_req_wdata | input | 1 | Value written to the request bit |
| cnt_load | input | 1 | Load strobe for the byte counter |
| cnt_load_val | input | CNT_W | Bytes expected in master receive |
| last_bit_rise | input | 1 | Pulse: clock rising edge of a byte's last data bit |
| ack_start | input | 1 | Pulse: acknowledge window opens |
| ack_end | input | 1 | Pulse: acknowledge window closes |
| ack_drive_low | output | 1 | 1 = pull data line low (acknowledge) |
| nack_req | output | 1 | Current state of the one-shot request bit |
| bytes_left | output | CNT_W | Master byte counter |

## Verification
A corrupted frozen decision appears as a wrong `ack_drive_low` level one cycle after `ack_start`. A request bit that is consumed at the wrong moment shows on `nack_req` one cycle after the offending `ack_end` or write. A counter that slips shows on `bytes_left` the cycle after `ack_end`, and it moves the refused byte by one. The bench's behavioural model is compared with all three outputs on every clock, so any of these faults surfaces within one cycle of its cause.

// File: rtl/rx_ack_pkg.sv
package rx_ack_pkg;
  localparam int unsigned DEF_CNT_W = 8;

  typedef struct packed {
    logic nack;      // frozen refusal for the current byte
    logic from_req;  // refusal came from the software request
  } ack_choice_t;
endpackage

// File: rtl/rx_ack_req_bit.sv
module rx_ack_req_bit (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  input  logic consume,
  output logic req
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst)          req_q <= 1'b0;
    else if (wr)      req_q <= wdata;   // software beats auto-clear
    else if (consume) req_q <= 1'b0;
  end

  assign req = req_q;

  AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (consume && !wr) |=> !req_q); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (consume && wr && wdata) |=> req_q); // R8
endmodule

// File: rtl/rx_ack_byte_cnt.sv
module rx_ack_byte_cnt #(
  parameter int unsigned CNT_W = rx_ack_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             near_end
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (step && (cnt_q != '0))    cnt_q <= cnt_q - ONE;
  end

  assign cnt      = cnt_q;
  assign near_end = (cnt_q <= ONE);

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R9
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/rx_ack_decide.sv
module rx_ack_decide (
  input  logic clk,
  input  logic rst,
  input  logic role_master,
  input  logic role_tx,
  input  logic req,
  input  logic near_end,
  input  logic last_bit,
  input  logic win_open,
  input  logic win_close,
  output logic ack_low,
  output logic consume,
  output logic cnt_step
);
  import rx_ack_pkg::*;

  ack_choice_t choice_q;
  logic        ack_low_q;
  logic        in_win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      choice_q <= '0;
    end else if (last_bit) begin
      if (role_tx) begin
        choice_q <= '0;
      end else begin
        choice_q.nack     <= req | (role_master & near_end);
        choice_q.from_req <= req;
      end
    end else if (win_close) begin
      choice_q.from_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_low_q <= 1'b0;
      in_win_q  <= 1'b0;
    end else if (win_close) begin
      ack_low_q <= 1'b0;
      in_win_q  <= 1'b0;
    end else if (win_open) begin
      ack_low_q <= !role_tx && !choice_q.nack;
      in_win_q  <= !role_tx;
    end
  end

  assign ack_low  = ack_low_q;
  assign consume  = win_close && !role_tx && choice_q.from_req;
  assign cnt_step = win_close && !role_tx && role_master;

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (in_win_q && !win_close && !win_open) |=> $stable(ack_low_q)); // R10
  AST_TX_SILENT: assert property (@(posedge clk) disable iff (rst)
    (win_open && !win_close && role_tx) |=> !ack_low_q); // R7
  AST_LAST_BYTE_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (last_bit && !role_tx && role_master && near_end) |=> choice_q.nack); // R3
  AST_REQ_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (last_bit && !role_tx && req) |=> choice_q.nack); // R4
endmodule

// File: rtl/rx_ack_ctrl.sv
module rx_ack_ctrl #(
  parameter int unsigned CNT_W = rx_ack_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             role_master,
  input  logic             role_tx,
  input  logic             nack_req_wr,
  input  logic             nack_req_wdata,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic             last_bit_rise,
  input  logic             ack_start,
  input  logic             ack_end,
  output logic             ack_drive_low,
  output logic             nack_req,
  output logic [CNT_W-1:0] bytes_left
);
  logic req_w, consume_w, step_w, near_end_w;

  rx_ack_req_bit u_req (
    .clk(clk), .rst(rst), .wr(nack_req_wr), .wdata(nack_req_wdata),
    .consume(consume_w), .req(req_w)
  );

  rx_ack_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_load_val),
    .step(step_w), .cnt(bytes_left), .near_end(near_end_w)
  );

  rx_ack_decide u_dec (
    .clk(clk), .rst(rst), .role_master(role_master), .role_tx(role_tx),
    .req(req_w), .near_end(near_end_w), .last_bit(last_bit_rise),
    .win_open(ack_start), .win_close(ack_end), .ack_low(ack_drive_low),
    .consume(consume_w), .cnt_step(step_w)
  );

  assign nack_req = req_w;

  AST_TX_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (role_tx && !nack_req_wr) |=> $stable(nack_req)); // R7
  AST_TX_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
    (role_tx && !cnt_load) |=> $stable(bytes_left)); // R7
endmodule

// File: tb/rx_ack_ctrl_tb_top.sv
module rx_ack_ctrl_tb_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic role_master = 1'b0, role_tx = 1'b0;
  logic nack_req_wr = 1'b0, nack_req_wdata = 1'b0;
  logic cnt_load = 1'b0;
  logic [CW-1:0] cnt_load_val = '0;
  logic last_bit_rise = 1'b0, ack_start = 1'b0, ack_end = 1'b0;
  logic ack_drive_low, nack_req;
  logic [CW-1:0] bytes_left;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  rx_ack_ctrl #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .role_master(role_master), .role_tx(role_tx),
    .nack_req_wr(nack_req_wr), .nack_req_wdata(nack_req_wdata),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .last_bit_rise(last_bit_rise), .ack_start(ack_start), .ack_end(ack_end),
    .ack_drive_low(ack_drive_low), .nack_req(nack_req), .bytes_left(bytes_left)
  );

  // Behavioural reference, written from the requirements
  bit m_req, m_refuse, m_by_req, m_ack;
  int m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_req <= 0; m_refuse <= 0; m_by_req <= 0; m_ack <= 0; m_cnt <= 0;
    end else begin
      if (nack_req_wr) m_req <= nack_req_wdata;
      else if (ack_end && !role_tx && m_by_req) m_req <= 0;
      if (cnt_load) m_cnt <= int'(cnt_load_val);
      else if (ack_end && !role_tx && role_master && m_cnt > 0) m_cnt <= m_cnt - 1;
      if (last_bit_rise) begin
        m_refuse <= !role_tx && (m_req || (role_master && m_cnt <= 1));
        m_by_req <= !role_tx && m_req;
      end else if (ack_end) m_by_req <= 0;
      if (ack_end) m_ack <= 0;
      else if (ack_start) m_ack <= !role_tx && !m_refuse;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ack_drive_low !== m_ack || nack_req !== m_req || int'(bytes_left) != m_cnt) begin
        failures++;
        $display("FAIL R10 model: ack=%0d/%0d req=%0d/%0d cnt=%0d/%0d (act/exp)",
                 ack_drive_low, m_ack, nack_req, m_req, bytes_left, m_cnt);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic sw_write(input bit v);
    @(negedge clk); nack_req_wr = 1; nack_req_wdata = v;
    @(negedge clk); nack_req_wr = 0;
  endtask

  // One received byte: last bit, gap, window open, two cycles, close.
  task automatic run_byte(input bit wr_last, input bit wr_mid, input bit wr_end,
                          output bit lvl1, output bit lvl2);
    @(negedge clk); last_bit_rise = 1;
    if (wr_last) begin nack_req_wr = 1; nack_req_wdata = 1; end
    @(negedge clk); last_bit_rise = 0; nack_req_wr = 0;
    @(negedge clk); ack_start = 1;
    @(negedge clk); ack_start = 0;
    lvl1 = ack_drive_low;
    if (wr_mid) begin nack_req_wr = 1; nack_req_wdata = 1; end
    @(negedge clk); nack_req_wr = 0;
    lvl2 = ack_drive_low;
    ack_end = 1;
    if (wr_end) begin nack_req_wr = 1; nack_req_wdata = 1; end
    @(negedge clk); ack_end = 0; nack_req_wr = 0;
  endtask

  initial begin
    bit a, b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ack after reset", ack_drive_low, 0);
    chk("R1 req after reset", nack_req, 0);
    chk("R1 cnt after reset", bytes_left, 0);

    // Slave receive, no request
    run_byte(0, 0, 0, a, b);
    chk("R2 slave ack byte1", a, 1);
    run_byte(0, 0, 0, a, b);
    chk("R2 slave ack byte2", b, 1);
    chk("R2 low released after window", ack_drive_low, 0);

    // Slave with request
    sw_write(1);
    run_byte(0, 0, 0, a, b);
    chk("R4 slave request refuses", a, 0);
    chk("R5 request cleared after refusal", nack_req, 0);
    run_byte(0, 0, 0, a, b);
    chk("R5 following byte acked", a, 1);

    // Late request
    run_byte(1, 0, 0, a, b);
    chk("R6 late request ignored this byte", a, 1);
    chk("R6 late request still pending", nack_req, 1);
    run_byte(0, 0, 0, a, b);
    chk("R6 late request refuses next byte", a, 0);
    chk("R6 cleared after use", nack_req, 0);

    // Master counting down
    role_master = 1;
    @(negedge clk); cnt_load = 1; cnt_load_val = 3;
    @(negedge clk); cnt_load = 0;
    chk("R9 load", bytes_left, 3);
    run_byte(0, 0, 0, a, b);
    chk("R3 master ack cnt3", a, 1);
    chk("R9 decrement", bytes_left, 2);
    run_byte(0, 0, 0, a, b);
    chk("R3 master ack cnt2", a, 1);
    run_byte(0, 0, 0, a, b);
    chk("R3 master refuses last byte", a, 0);
    chk("R9 reaches zero", bytes_left, 0);
    run_byte(0, 0, 0, a, b);
    chk("R3 master refuses at zero", a, 0);
    chk("R9 saturates", bytes_left, 0);

    // Master request preempts counter
    @(negedge clk); cnt_load = 1; cnt_load_val = 5;
    @(negedge clk); cnt_load = 0;
    sw_write(1);
    run_byte(0, 0, 0, a, b);
    chk("R4 master request refuses cnt5", a, 0);
    chk("R5 master request cleared", nack_req, 0);
    chk("R9 cnt after request byte", bytes_left, 4);

    // Load beats decrement
    @(negedge clk); ack_end = 1; cnt_load = 1; cnt_load_val = 9;
    @(negedge clk); ack_end = 0; cnt_load = 0;
    chk("R9 load wins over step", bytes_left, 9);

    // Transmitter role
    sw_write(1);
    role_tx = 1;
    run_byte(0, 0, 0, a, b);
    chk("R7 tx no drive", a | b, 0);
    chk("R7 tx keeps request", nack_req, 1);
    chk("R7 tx keeps counter", bytes_left, 9);
    role_tx = 0;

    // Write during auto-clear
    run_byte(0, 0, 1, a, b);
    chk("R8 refused with request", a, 0);
    chk("R8 write wins over clear", nack_req, 1);
    run_byte(0, 0, 0, a, b);
    chk("R8 renewed request refuses", a, 0);
    chk("R8 renewed request consumed", nack_req, 0);

    // Write inside window
    role_master = 0;
    run_byte(0, 1, 0, a, b);
    chk("R10 level before mid write", a, 1);
    chk("R10 level held after mid write", b, 1);
    chk("R10 mid request pending", nack_req, 1);
    run_byte(0, 0, 0, a, b);
    chk("R10 mid request used next byte", a, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule